// File: doc/BRIEF.md
# Master-Clocked Converter Serial Port

This block is the serial front end of a measurement converter, used where the converter drives the serial clock itself. It holds three 24-bit registers: a control register, a calibration register and an output register. The output register is loaded from the conversion path through a one-cycle strobe. A host asks for a read by pulling `rd_req_n` low, or for a write by pulling `wr_req_n` low. `reg_sel` picks the register. The port then produces its own serial clock, which is the system clock divided by `DIV`, and runs the whole frame. After the frame it releases both serial lines.

The serial clock idles high, as a line with a pull-up would. When a frame starts, the clock stays high for half a period. Each bit then gets one low phase followed by one high phase. The host samples read data on each rising edge and changes write data after each falling edge.

The active-low flag `ready_n` shows that an unread output word is waiting. It returns high on the falling edge after the last bit of an output-register read. The same edge that raises it also switches off the clock and data drivers.

Top module: `msp_master_port`

## Requirements
- R1: After reset, `ready_n` is 1, `sclk_oe` and `sdata_oe` are 0, and `sclk_out` is 1. The control and calibration registers hold 0, so output reads are 16 bits wide and an access with `reg_sel`=1 reaches the output register.
- R2: A falling `rd_req_n` with an accepted target starts a read frame on the next clock. From that clock, `sclk_oe` and `sdata_oe` are 1, and `sclk_out` stays high for DIV/2 system cycles. After that, each bit takes DIV cycles: DIV/2 cycles low, then DIV/2 cycles high.
- R3: Read data goes out MSB first, and the MSB is present from the first frame cycle. Each later bit appears on a falling edge of `sclk_out`. The first falling edge leaves the data unchanged, and the data never changes at any other time within a frame.
- R4: The frame ends on the falling edge that follows the high phase of the last bit. On that cycle `sclk_oe` and `sdata_oe` drop, and `sclk_out` returns to idle high. An output-register read also raises `ready_n` on that cycle.
- R5: Control bit 1 sets the output word length: 1 gives all 24 bits, and 0 gives the upper 16 bits. Control and calibration transfers are always 24 bits long.
- R6: The target register is set by `reg_sel`, which is sampled when the frame starts.
  - `reg_sel`=0 selects the control register.
  - For a read with `reg_sel`=1, control bit 0 chooses: 1 selects the calibration register, and 0 selects the output register.
  - A write with `reg_sel`=1 always goes to the calibration register.
- R7: A falling `wr_req_n` while `rd_req_n` is high starts a 24-bit write frame. `sdata_in` is captured MSB first on each rising edge of `sclk_out`, and the target register takes the word when the frame ends. `sdata_oe` stays 0, and `ready_n` is not changed.
- R8: Outside an output-register read frame, `sample_valid` loads `sample_data` into the output register and drives `ready_n` low. During such a frame, the strobe is ignored and that word is lost.
- R9: A read request to the output register while `ready_n` is 1 produces no clock and no data.
- R10: If `rd_req_n` and `wr_req_n` fall in the same cycle, only the read runs and no register is written.
- R11: Reading the control or calibration register leaves `ready_n` as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_req_n | input | 1 | Active-low read request; its falling edge starts a read |
| wr_req_n | input | 1 | Active-low write request; its falling edge starts a write |
| reg_sel | input | 1 | Register select, sampled at frame start |
| sample_valid | input | 1 | Strobe from the conversion path: a new word is ready |
| sample_data | input | REG_W | New conversion word |
| sdata_in | input | 1 | Serial write data from the host |
| sdata_out | output | 1 | Serial read data |
| sdata_oe | output | 1 | Drive enable for `sdata_out` |
| sclk_out | output | 1 | Generated serial clock, high when idle |
| sclk_oe | output | 1 | Drive enable for `sclk_out` |
| ready_n | output | 1 | Active-low flag for an unread output word |

## Verification
The bench targets the following corners:
- **Lead-in high phase.** If the first falling edge shifted data, the host would lose the MSB and see every bit one place early.
- **Frame length.** An off-by-one in the frame length would show up as an extra or missing clock pulse, or as a `ready_n` that rises one phase late.
- **Strobe during a read.** A new sample arriving in the middle of an output read must be dropped. A design that accepted it would either corrupt the bits being shifted out or leave `ready_n` low after the read.
- **Read refused while `ready_n` is high.** A design that ignored this would clock out stale data.
- **Simultaneous requests.** With both requests falling together, a design that let the write through would overwrite the control register, and the read-back afterwards would show it.

// File: rtl/msp_pkg.sv
package msp_pkg;

    typedef enum logic [1:0] {
        DST_CTRL = 2'd0,
        DST_CAL  = 2'd1,
        DST_OUT  = 2'd2
    } dst_e;

    localparam int unsigned CAL_SEL_BIT = 0;
    localparam int unsigned LONG_BIT    = 1;

endpackage

// File: rtl/msp_clkdiv.sv
module msp_clkdiv #(
    parameter int unsigned HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic sclk_q,
    output logic rise,
    output logic fall
);
    localparam int unsigned CW = (HALF > 1) ? $clog2(HALF) : 1;

    typedef struct packed {
        logic [CW-1:0] div;
        logic          sclk;
    } div_t;

    div_t q, d;
    logic wrap;

    always_comb begin
        d    = q;
        wrap = (q.div == CW'(HALF - 1));
        if (!run) begin
            d.div  = '0;
            d.sclk = 1'b1;
        end else if (wrap) begin
            d.div  = '0;
            d.sclk = ~q.sclk;
        end else begin
            d.div = q.div + 1'b1;
        end
        rise = run && wrap && !q.sclk;
        fall = run && wrap && q.sclk;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.div  <= '0;
            q.sclk <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_q = q.sclk;

endmodule

// File: rtl/msp_shifter.sv
module msp_shifter #(
    parameter int unsigned W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         capture,
    input  logic         din,
    output logic [W-1:0] word,
    output logic         msb
);
    logic [W-1:0] sr_d, sr_q;

    always_comb begin
        sr_d = sr_q;
        if (load) begin
            sr_d = load_val;
        end else if (shift) begin
            sr_d = {sr_q[W-2:0], 1'b0};
        end else if (capture) begin
            sr_d = {sr_q[W-2:0], din};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sr_q <= '0;
        else        sr_q <= sr_d;
    end

    assign word = sr_q;
    assign msb  = sr_q[W-1];

endmodule

// File: rtl/msp_master_port.sv
module msp_master_port
    import msp_pkg::*;
#(
    parameter int unsigned REG_W    = 24,
    parameter int unsigned SHORT_W  = 16,
    parameter int unsigned DIV      = 4,
    parameter logic [23:0] CTRL_RST = 24'h0,
    parameter logic [23:0] CAL_RST  = 24'h0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_req_n,
    input  logic             wr_req_n,
    input  logic             reg_sel,
    input  logic             sample_valid,
    input  logic [REG_W-1:0] sample_data,
    input  logic             sdata_in,
    output logic             sdata_out,
    output logic             sdata_oe,
    output logic             sclk_out,
    output logic             sclk_oe,
    output logic             ready_n
);
    localparam int unsigned HALF  = DIV / 2;
    localparam int unsigned CNT_W = $clog2(REG_W + 1);
    localparam int unsigned PAD   = REG_W - SHORT_W;
    localparam logic [REG_W-1:0] SHORT_MASK = ~((REG_W'(1) << PAD) - REG_W'(1));

    typedef struct packed {
        logic             active;
        logic             is_rd;
        dst_e             dst;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] nbits;
        logic             rdy_n;
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] cal;
        logic [REG_W-1:0] outr;
        logic             rd_p;
        logic             wr_p;
    } st_t;

    st_t q, d;

    logic             sclk_q, rise, fall;
    logic             ld, sh, cap, sr_msb;
    logic [REG_W-1:0] ld_val, sr_word;

    msp_clkdiv #(.HALF(HALF)) i_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (q.active),
        .sclk_q (sclk_q),
        .rise   (rise),
        .fall   (fall)
    );

    msp_shifter #(.W(REG_W)) i_sr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ld),
        .load_val (ld_val),
        .shift    (sh),
        .capture  (cap),
        .din      (sdata_in),
        .word     (sr_word),
        .msb      (sr_msb)
    );

    logic rd_fall, wr_fall, out_rd;

    always_comb begin
        d       = q;
        ld      = 1'b0;
        ld_val  = '0;
        sh      = 1'b0;
        cap     = 1'b0;
        rd_fall = q.rd_p & ~rd_req_n;
        wr_fall = q.wr_p & ~wr_req_n & rd_req_n;
        out_rd  = q.active & q.is_rd & (q.dst == DST_OUT);
        d.rd_p  = rd_req_n;
        d.wr_p  = wr_req_n;

        if (!q.active) begin
            if (rd_fall) begin
                if (!reg_sel) begin
                    d.active = 1'b1;
                    d.dst    = DST_CTRL;
                    d.len    = CNT_W'(REG_W);
                    ld_val   = q.ctrl;
                end else if (q.ctrl[CAL_SEL_BIT]) begin
                    d.active = 1'b1;
                    d.dst    = DST_CAL;
                    d.len    = CNT_W'(REG_W);
                    ld_val   = q.cal;
                end else if (!q.rdy_n) begin
                    d.active = 1'b1;
                    d.dst    = DST_OUT;
                    d.len    = q.ctrl[LONG_BIT] ? CNT_W'(REG_W) : CNT_W'(SHORT_W);
                    ld_val   = q.ctrl[LONG_BIT] ? q.outr : (q.outr & SHORT_MASK);
                end
                d.is_rd = 1'b1;
                d.nbits = '0;
                ld      = d.active;
            end else if (wr_fall) begin
                d.active = 1'b1;
                d.is_rd  = 1'b0;
                d.dst    = reg_sel ? DST_CAL : DST_CTRL;
                d.len    = CNT_W'(REG_W);
                d.nbits  = '0;
            end
        end else begin
            if (rise) begin
                d.nbits = q.nbits + 1'b1;
                cap     = ~q.is_rd;
            end
            if (fall) begin
                if (q.nbits == q.len) begin
                    d.active = 1'b0;
                    if (!q.is_rd) begin
                        if (q.dst == DST_CTRL) d.ctrl = sr_word;
                        else                   d.cal  = sr_word;
                    end else if (q.dst == DST_OUT) begin
                        d.rdy_n = 1'b1;
                    end
                end else if (q.is_rd && q.nbits != '0) begin
                    sh = 1'b1;
                end
            end
        end

        if (sample_valid && !out_rd) begin
            d.outr  = sample_data;
            d.rdy_n = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.active <= 1'b0;
            q.is_rd  <= 1'b0;
            q.dst    <= DST_CTRL;
            q.len    <= '0;
            q.nbits  <= '0;
            q.rdy_n  <= 1'b1;
            q.ctrl   <= CTRL_RST[REG_W-1:0];
            q.cal    <= CAL_RST[REG_W-1:0];
            q.outr   <= '0;
            q.rd_p   <= 1'b1;
            q.wr_p   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign sclk_oe   = q.active;
    assign sclk_out  = q.active ? sclk_q : 1'b1;
    assign sdata_oe  = q.active & q.is_rd;
    assign sdata_out = sdata_oe ? sr_msb : 1'b0;
    assign ready_n   = q.rdy_n;

    AST_DATA_NEEDS_CLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        sdata_oe |-> sclk_oe); // R2

    AST_DATA_MOVES_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        (sdata_oe && $past(sdata_oe) && !$fell(sclk_out)) |-> $stable(sdata_out)); // R3

    AST_READY_RISE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ready_n) |-> (!sclk_oe && !sdata_oe)); // R4

    AST_WRITE_KEEPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_oe && !sdata_oe) |=> !$rose(ready_n)); // R7

    AST_READY_FALL_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ready_n) |-> $past(sample_valid)); // R8

endmodule

// File: tb/test_msp_master_port.sv
`timescale 1ns/1ps
module test_msp_master_port;
    localparam int HALF = 2;
    localparam int DIV  = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rd_req_n = 1'b1, wr_req_n = 1'b1, reg_sel = 1'b0;
    logic        sample_valid = 1'b0;
    logic [23:0] sample_data = '0;
    logic        sdata_in = 1'b0;
    logic        sdata_out, sdata_oe, sclk_out, sclk_oe, ready_n;

    msp_master_port #(.REG_W(24), .SHORT_W(16), .DIV(DIV)) i_msp_master_port (
        .clk(clk), .rst_n(rst_n), .rd_req_n(rd_req_n), .wr_req_n(wr_req_n),
        .reg_sel(reg_sel), .sample_valid(sample_valid), .sample_data(sample_data),
        .sdata_in(sdata_in), .sdata_out(sdata_out), .sdata_oe(sdata_oe),
        .sclk_out(sclk_out), .sclk_oe(sclk_oe), .ready_n(ready_n)
    );

    always #4 clk = ~clk;

    int n_chk = 0, n_fail = 0, cyc = 0;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    // behavioural reference model, advanced on each rising clock
    int          m_act = 0, m_rd = 0, m_dst = 0, m_t = 0, m_len = 0;
    logic [23:0] m_ctrl = 0, m_cal = 0, m_out = 0, m_word = 0;
    logic        m_rdy = 1'b1, m_rp = 1'b1, m_wp = 1'b1;

    // host shift-register model
    logic [23:0] h_wr = 0, h_rd = 0;
    int          h_widx = 0, h_ridx = 0;
    logic        h_prev = 1'b1, saw_drive = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act = 0; m_ctrl = 0; m_cal = 0; m_out = 0; m_rdy = 1'b1;
            m_rp = 1'b1; m_wp = 1'b1;
        end else begin
            automatic int blocked = m_act && m_rd && m_dst == 2;
            if (m_act != 0) begin
                m_t++;
                if (m_t == HALF + m_len * DIV) begin
                    m_act = 0;
                    if (m_rd == 0) begin
                        if (m_dst == 0) m_ctrl = h_wr; else m_cal = h_wr;
                    end else if (m_dst == 2) m_rdy = 1'b1;
                end
            end else if (m_rp && !rd_req_n) begin
                m_rd = 1; m_t = 0; m_len = 24;
                if (!reg_sel) begin m_act = 1; m_dst = 0; m_word = m_ctrl; end
                else if (m_ctrl[0]) begin m_act = 1; m_dst = 1; m_word = m_cal; end
                else if (!m_rdy) begin
                    m_act = 1; m_dst = 2;
                    if (m_ctrl[1]) m_word = m_out;
                    else begin m_len = 16; m_word = m_out >> 8; end
                end
            end else if (m_wp && !wr_req_n && rd_req_n) begin
                m_act = 1; m_rd = 0; m_t = 0; m_len = 24; m_dst = reg_sel ? 1 : 0;
            end
            if (sample_valid && blocked == 0) begin m_out = sample_data; m_rdy = 1'b0; end
            m_rp = rd_req_n; m_wp = wr_req_n;
        end
    end

    // per-cycle comparison and host behaviour, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic logic exp_sclk = 1'b1;
            automatic int   idx = 0;
            if (m_act != 0 && m_t >= HALF) begin
                exp_sclk = (((m_t - HALF) % DIV) < HALF) ? 1'b0 : 1'b1;
                idx = (m_t - HALF) / DIV;
            end
            check("R2 sclk_oe", 32'(sclk_oe), 32'(m_act != 0));
            check("R2 sclk_out", 32'(sclk_out), 32'(exp_sclk));
            check("R4 sdata_oe", 32'(sdata_oe), 32'(m_act != 0 && m_rd != 0));
            if (m_act != 0 && m_rd != 0)
                check("R3 sdata_out", 32'(sdata_out), 32'(m_word[m_len - 1 - idx]));
            check("R8 ready_n", 32'(ready_n), 32'(m_rdy));
        end
        if (sclk_oe || sdata_oe) saw_drive = 1'b1;
        if (sclk_oe) begin
            if (h_prev && !sclk_out && h_widx < 24) begin
                sdata_in = h_wr[23 - h_widx];
                h_widx++;
            end
            if (!h_prev && sclk_out && sdata_oe) begin
                h_rd = {h_rd[22:0], sdata_out};
                h_ridx++;
            end
        end
        h_prev = sclk_out;
    end

    task automatic pulse_sample(input logic [23:0] v);
        @(negedge clk); sample_data = v; sample_valid = 1'b1;
        @(negedge clk); sample_valid = 1'b0;
    endtask

    task automatic do_read(input logic sel, input int nb, input logic [23:0] exp,
                           input string tag, input logic both, input logic mid,
                           input logic [23:0] mid_val);
        @(negedge clk);
        reg_sel = sel; h_rd = 0; h_ridx = 0; rd_req_n = 1'b0;
        if (both) wr_req_n = 1'b0;
        for (int i = 0; i < 10 && !sclk_oe; i++) @(negedge clk);
        if (mid) begin
            repeat (20) @(negedge clk);
            sample_data = mid_val; sample_valid = 1'b1;
            @(negedge clk); sample_valid = 1'b0;
        end
        for (int i = 0; i < 400 && sclk_oe; i++) @(negedge clk);
        rd_req_n = 1'b1; wr_req_n = 1'b1;
        check({tag, " word"}, 32'(h_rd), 32'(exp));
        check({tag, " bits"}, 32'(h_ridx), 32'(nb));
    endtask

    task automatic do_write(input logic sel, input logic [23:0] w);
        @(negedge clk);
        reg_sel = sel; h_wr = w; h_widx = 0; wr_req_n = 1'b0;
        for (int i = 0; i < 10 && !sclk_oe; i++) @(negedge clk);
        for (int i = 0; i < 400 && sclk_oe; i++) @(negedge clk);
        wr_req_n = 1'b1;
        check("R7 bits driven", 32'(h_widx), 32'd24);
    endtask

    task automatic finish_up;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            finish_up();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 ready_n", 32'(ready_n), 32'd1);
        check("R1 sclk_oe", 32'(sclk_oe), 32'd0);
        check("R1 sdata_oe", 32'(sdata_oe), 32'd0);
        check("R1 sclk_out", 32'(sclk_out), 32'd1);
        do_read(1'b0, 24, 24'h0, "R1 ctrl reset", 1'b0, 1'b0, 24'h0);
        check("R11 ready after ctrl read", 32'(ready_n), 32'd1);

        // R9: output read refused while ready_n is high
        @(negedge clk); reg_sel = 1'b1; saw_drive = 1'b0; rd_req_n = 1'b0;
        repeat (30) @(negedge clk);
        rd_req_n = 1'b1;
        check("R9 no drive", 32'(saw_drive), 32'd0);

        pulse_sample(24'hA5C3E7);
        check("R8 ready low", 32'(ready_n), 32'd0);
        do_read(1'b1, 16, 24'h00A5C3, "R5 short out", 1'b0, 1'b0, 24'h0);
        check("R4 ready high", 32'(ready_n), 32'd1);

        do_write(1'b0, 24'h000002);
        do_read(1'b0, 24, 24'h000002, "R7 ctrl readback", 1'b0, 1'b0, 24'h0);
        pulse_sample(24'h123456);
        do_read(1'b1, 24, 24'h123456, "R5 long out", 1'b0, 1'b0, 24'h0);

        do_write(1'b1, 24'hC0FFEE);
        pulse_sample(24'h654321);
        do_write(1'b0, 24'h000003);
        check("R7 ready kept", 32'(ready_n), 32'd0);
        do_read(1'b1, 24, 24'hC0FFEE, "R6 cal read", 1'b0, 1'b0, 24'h0);
        check("R11 ready after cal read", 32'(ready_n), 32'd0);
        do_write(1'b0, 24'h000002);
        do_read(1'b1, 24, 24'h654321, "R6 out path", 1'b0, 1'b0, 24'h0);

        pulse_sample(24'h111111);
        do_read(1'b1, 24, 24'h111111, "R8 mid sample", 1'b0, 1'b1, 24'h222222);
        check("R8 ready after lost word", 32'(ready_n), 32'd1);
        pulse_sample(24'h333333);
        do_read(1'b1, 24, 24'h333333, "R8 next word", 1'b0, 1'b0, 24'h0);

        h_wr = 24'hFFFFFF;
        do_read(1'b0, 24, 24'h000002, "R10 both fall", 1'b1, 1'b0, 24'h0);
        do_read(1'b0, 24, 24'h000002, "R10 ctrl kept", 1'b0, 1'b0, 24'h0);

        repeat (5) @(negedge clk);
        finish_up();
    end
endmodule